// File: doc/BRIEF.md
# RAM Controller Error-Interrupt Register Block

This block is the software-visible error-reporting register set of an on-chip RAM controller. Hardware error detectors pulse one or more of the 11 event inputs. Each pulse latches a sticky status bit. Software clears a status bit by writing 1 to it.

Masking is controlled through two strobe registers. A write to the enable register unmasks the bits written as 1, and a write to the disable register masks them. The mask itself can be read but not written. The single level interrupt is high while any status bit is set and its mask bit is clear. All sources start masked after reset.

Two more registers sit beside the interrupt logic:
- A 4-bit error-control register, which resets to all ones.
- A read-only implementation register, which reports the RAM size that was chosen at elaboration as a small code.

The register port is a 32-bit valid/write bus. It accepts only full-word accesses and returns read data one cycle after a read request. A small two-state machine manages the read response. In `ST_IDLE`, an accepted read moves it to `ST_RESP`. In `ST_RESP`, it presents the response and stays there if another read arrives, or otherwise returns to `ST_IDLE`.

Top module: `ramc_err_regs`

## Requirements
- R1: After synchronous active-low reset, the registers take these values: status 0, mask 0x7ff, error control 0xf, and interrupt low.
- R2: An event input bit that is high at a clock edge sets the matching status bit (offset 0x04, bits 10:0). Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R3: If an event pulse and a write-1 clear of the same status bit fall in the same cycle, the bit stays set.
- R4: Writing to the enable register (0x0C) clears the mask bits written as 1. Writing to the disable register (0x10) sets them. A write to the mask offset (0x08) has no effect.
- R5: The enable and disable offsets always read as zero.
- R6: The interrupt output is high exactly when some status bit is 1 and its mask bit is 0.
- R7: The error-control register at 0x00 stores bits 3:0 of a write, and its bits 31:4 read as zero.
- R8: The implementation register at 0x14 reads the size code in bits 3:0, and writes to it are ignored. The codes are 0 for 64 KiB, 1 for 128 KiB, 2 for 256 KiB, 3 for 512 KiB and 4 for 1024 KiB (the default). Any other size stops elaboration.
- R9: Bits 31:11 of status and mask read as zero, and any unmapped byte offset reads as zero.
- R10: A read request (valid high, write low) produces `bus_rvalid` high on the next cycle, together with its data. An access whose byte strobes are not all 1 has no write effect and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte strobes; all four are required |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| evt_i | input | NUM_EVT | Error event pulses |
| irq_o | output | 1 | Level interrupt |

## Verification
The status and mask logic is exercised with single-bit and multi-bit event patterns, so that clearing one bit can be seen to leave its neighbours alone. An event that coincides with a clear is tested to separate set-priority from clear-priority. The interrupt is checked with a source masked, then unmasked, then cleared, and with two sources of which only one is unmasked. This distinguishes an AND-NOT mask from an inverted or ignored mask. Partial-strobe writes, writes to read-only offsets and reads of unmapped offsets show that these accesses change nothing and return zero.

// File: rtl/ramc_pkg.sv
package ramc_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned STRB_W = DATA_W / 8;

    localparam logic [7:0] OFS_ERRCTL  = 8'h00;
    localparam logic [7:0] OFS_STATUS  = 8'h04;
    localparam logic [7:0] OFS_MASK    = 8'h08;
    localparam logic [7:0] OFS_ENABLE  = 8'h0C;
    localparam logic [7:0] OFS_DISABLE = 8'h10;
    localparam logic [7:0] OFS_IMPL    = 8'h14;

    typedef enum logic {ST_IDLE, ST_RESP} bus_state_e;

    function automatic logic [3:0] size_code(input int unsigned kib);
        case (kib)
            64:      return 4'd0;
            128:     return 4'd1;
            256:     return 4'd2;
            512:     return 4'd3;
            1024:    return 4'd4;
            default: return 4'hF;
        endcase
    endfunction
endpackage

// File: rtl/ramc_bus_fsm.sv
module ramc_bus_fsm
    import ramc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [STRB_W-1:0] strb,
    output logic              wr_errctl,
    output logic              wr_status,
    output logic              wr_enable,
    output logic              wr_disable,
    output logic              rd_accept,
    output logic              full_word,
    output logic              rvalid
);
    bus_state_e state_q, state_d;
    logic       wr_ok;

    assign full_word = &strb;
    assign wr_ok     = valid && write && full_word;
    assign rd_accept = valid && !write;

    // Write strobes: only full-word writes to a mapped writable offset
    assign wr_errctl  = wr_ok && (addr == ADDR_W'(OFS_ERRCTL));
    assign wr_status  = wr_ok && (addr == ADDR_W'(OFS_STATUS));
    assign wr_enable  = wr_ok && (addr == ADDR_W'(OFS_ENABLE));
    assign wr_disable = wr_ok && (addr == ADDR_W'(OFS_DISABLE));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_accept) state_d = ST_RESP;
            ST_RESP: state_d = rd_accept ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rvalid = 1'b0;
        unique case (state_q)
            ST_IDLE: rvalid = 1'b0;
            ST_RESP: rvalid = 1'b1;
            default: rvalid = 1'b0;
        endcase
    end
endmodule

// File: rtl/ramc_irq_core.sv
module ramc_irq_core #(
    parameter int unsigned NUM_EVT = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               wr_status,
    input  logic               wr_enable,
    input  logic               wr_disable,
    input  logic [NUM_EVT-1:0] wdata,
    output logic [NUM_EVT-1:0] status,
    output logic [NUM_EVT-1:0] mask,
    output logic               irq
);
    logic [NUM_EVT-1:0] clr_bits;

    assign clr_bits = wr_status ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '1;
        end else begin
            // set has priority over write-1-to-clear
            status <= (status & ~clr_bits) | evt;
            if (wr_enable)       mask <= mask & ~wdata;
            else if (wr_disable) mask <= mask | wdata;
        end
    end

    assign irq = |(status & ~mask);
endmodule

// File: rtl/ramc_err_regs.sv
module ramc_err_regs
    import ramc_pkg::*;
#(
    parameter int unsigned NUM_EVT  = 11,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned RAM_KIB  = 1024,
    parameter int unsigned ERRCTL_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [STRB_W-1:0]   bus_strb,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    input  logic [NUM_EVT-1:0]  evt_i,
    output logic                irq_o
);
    localparam logic [3:0] SIZE_CODE = size_code(RAM_KIB);

    generate
        if (SIZE_CODE == 4'hF) begin : g_bad_size
            $error("unsupported RAM size");
        end
    endgenerate

    logic               wr_errctl, wr_status, wr_enable, wr_disable;
    logic               rd_accept, full_word;
    logic [NUM_EVT-1:0] status_q, mask_q;
    logic [ERRCTL_W-1:0] errctl_q;
    logic [DATA_W-1:0]  rd_mux;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_EVT];

    ramc_bus_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .valid(bus_valid), .write(bus_write),
        .addr(bus_addr), .strb(bus_strb),
        .wr_errctl(wr_errctl), .wr_status(wr_status),
        .wr_enable(wr_enable), .wr_disable(wr_disable),
        .rd_accept(rd_accept), .full_word(full_word), .rvalid(bus_rvalid)
    );

    ramc_irq_core #(.NUM_EVT(NUM_EVT)) u_irq (
        .clk(clk), .rst_n(rst_n), .evt(evt_i),
        .wr_status(wr_status), .wr_enable(wr_enable), .wr_disable(wr_disable),
        .wdata(bus_wdata[NUM_EVT-1:0]),
        .status(status_q), .mask(mask_q), .irq(irq_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)         errctl_q <= '1;
        else if (wr_errctl) errctl_q <= bus_wdata[ERRCTL_W-1:0];
    end

    always_comb begin
        rd_mux = '0;
        if (full_word) begin
            case (bus_addr)
                ADDR_W'(OFS_ERRCTL): rd_mux = DATA_W'(errctl_q);
                ADDR_W'(OFS_STATUS): rd_mux = DATA_W'(status_q);
                ADDR_W'(OFS_MASK):   rd_mux = DATA_W'(mask_q);
                ADDR_W'(OFS_IMPL):   rd_mux = DATA_W'(SIZE_CODE);
                default:             rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         bus_rdata <= '0;
        else if (rd_accept) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/ramc_err_regs_chk.sv
module ramc_err_regs_chk
    import ramc_pkg::*;
#(
    parameter int unsigned NUM_EVT = 11,
    parameter int unsigned ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [STRB_W-1:0]  bus_strb,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               bus_rvalid,
    input logic [NUM_EVT-1:0] evt_i,
    input logic [NUM_EVT-1:0] status_q,
    input logic [NUM_EVT-1:0] mask_q,
    input logic               irq_o
);
    logic mask_wr;
    assign mask_wr = bus_valid && bus_write && (&bus_strb) &&
                     (bus_addr == ADDR_W'(OFS_ENABLE) || bus_addr == ADDR_W'(OFS_DISABLE));

    assert_reset_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == '1 && status_q == '0));

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

    assert_mask_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q));

    assert_strobe_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && (bus_addr == ADDR_W'(OFS_ENABLE) ||
         bus_addr == ADDR_W'(OFS_DISABLE))) |=> (bus_rdata == '0));

    assert_irq_needs_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_q != '0));

    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq_o);

    assert_read_response_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);
endmodule

bind ramc_err_regs ramc_err_regs_chk #(.NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .evt_i(evt_i), .status_q(status_q),
    .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/ramc_err_regs_test.sv
`timescale 1ns/1ps
module ramc_err_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_strb = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [10:0] evt_i = '0;
    logic        irq_o;
    int          n_chk = 0, n_bad = 0;
    logic [31:0] rd;

    always #2 clk = ~clk;

    ramc_err_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_strb(bus_strb),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .evt_i(evt_i), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_strb = s;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; bus_strb = 0;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d, input logic [3:0] s = 4'hF);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a; bus_strb = s;
        @(negedge clk);
        bus_valid = 0; bus_strb = 0;
        chk("R10 rvalid", {31'b0, bus_rvalid}, 32'h1);
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [10:0] e);
        @(negedge clk); evt_i = e;
        @(negedge clk); evt_i = '0;
    endtask

    task automatic t_reset;
        rdreg(8'h04, rd); chk("R1 status", rd, 0);
        rdreg(8'h08, rd); chk("R1 mask", rd, 32'h7ff);
        rdreg(8'h00, rd); chk("R1 errctl", rd, 32'hf);
        chk("R1 irq", {31'b0, irq_o}, 0);
    endtask

    task automatic t_status;
        pulse(11'h405);
        rdreg(8'h04, rd); chk("R2 set", rd, 32'h405);
        wr(8'h04, 32'h004);
        rdreg(8'h04, rd); chk("R2 w1c", rd, 32'h401);
        wr(8'h04, 32'h000);
        rdreg(8'h04, rd); chk("R2 write0", rd, 32'h401);
        wr(8'h04, 32'hFFFF_FFFF);
        rdreg(8'h04, rd); chk("R2 clear all", rd, 0);
    endtask

    task automatic t_collision;
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 8'h04; bus_wdata = 32'h6; bus_strb = 4'hF;
        evt_i = 11'h2;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; bus_strb = 0; evt_i = 0;
        rdreg(8'h04, rd); chk("R3 set wins", rd, 32'h2);
        wr(8'h04, 32'h2);
    endtask

    task automatic t_mask_irq;
        pulse(11'h030);
        chk("R6 masked", {31'b0, irq_o}, 0);
        wr(8'h0C, 32'h010);
        rdreg(8'h08, rd); chk("R4 enable", rd, 32'h7ef);
        chk("R6 unmasked", {31'b0, irq_o}, 1);
        wr(8'h08, 32'h0);
        rdreg(8'h08, rd); chk("R4 direct ignored", rd, 32'h7ef);
        wr(8'h10, 32'h010);
        rdreg(8'h08, rd); chk("R4 disable", rd, 32'h7ff);
        chk("R6 remasked", {31'b0, irq_o}, 0);
        wr(8'h0C, 32'h010);
        wr(8'h04, 32'h010);
        chk("R6 other masked", {31'b0, irq_o}, 0);
        rdreg(8'h0C, rd); chk("R5 enable reads 0", rd, 0);
        rdreg(8'h10, rd); chk("R5 disable reads 0", rd, 0);
        wr(8'h04, 32'h7ff);
        wr(8'h10, 32'h7ff);
    endtask

    task automatic t_errctl_impl;
        wr(8'h00, 32'hFFFF_FFF5);
        rdreg(8'h00, rd); chk("R7 errctl", rd, 32'h5);
        rdreg(8'h14, rd); chk("R8 size code", rd, 32'h4);
        wr(8'h14, 32'h0);
        rdreg(8'h14, rd); chk("R8 ro", rd, 32'h4);
    endtask

    task automatic t_reserved_partial;
        pulse(11'h7ff);
        rdreg(8'h04, rd); chk("R9 status upper", rd, 32'h7ff);
        rdreg(8'h40, rd); chk("R9 unmapped", rd, 0);
        rdreg(8'h06, rd); chk("R9 misaligned", rd, 0);
        wr(8'h04, 32'h7ff, 4'h3);
        rdreg(8'h04, rd); chk("R10 partial write", rd, 32'h7ff);
        rdreg(8'h04, rd, 4'h1); chk("R10 partial read", rd, 0);
        wr(8'h04, 32'h7ff);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_status;
        t_collision;
        t_mask_irq;
        t_errctl_impl;
        t_reserved_partial;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule